// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block supervises a processor. A free-running prescaler divides the system clock, and a selected prescaler tap advances a two-bit overflow counter. When that counter wraps past its last state the watchdog fires. Depending on one control bit, it either raises a sticky active-low reset request or emits a single-cycle interrupt pulse. Software keeps the watchdog quiet by writing one fixed key byte to a clear register at regular intervals. That write zeroes only the two-bit counter and leaves the prescaler phase alone. As a result, the real time from a clear to the overflow lies above three quarters of the selected period and at most the full period, and software must service the watchdog more often than the three-quarter bound.

The watchdog runs as soon as reset is released. Its default setting is the longest period, with overflow routed to reset. A low-power indication freezes the prescaler and the counter together, and counting resumes from the held values when the indication drops. Register writes use a plain single-cycle strobe with a select bit. There is no back-pressure: every strobed write takes effect at the next clock edge.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is enabled and counting with time code 2'b00 and overflow routed to reset. While reset is held, irq_o is 0 and rst_req_n_o is 1.
- R2: A control write uses wr_sel_i=0. The layout is wr_data_i bit 3 = enable, bits [2:1] = time code, bit 0 = output select. Time code 00, 01, 10 and 11 give periods of 2^(BASE_LOG2+6), 2^(BASE_LOG2+4), 2^(BASE_LOG2+2) and 2^BASE_LOG2 clocks. Each counter step is one quarter of the period.
- R3: A write with wr_sel_i=1 and wr_data_i=8'h4E clears only the two-bit counter. The prescaler keeps its phase, so the next overflow comes more than 3/4 of the period and at most one full period after the clearing edge.
- R4: A write with wr_sel_i=1 and any other data value leaves the counter untouched, so overflow timing is unchanged.
- R5: With output select = 1, an overflow drives rst_req_n_o low from the cycle after the overflow edge. It stays low until rst_n is asserted.
- R6: With output select = 0, each overflow gives irq_o high for exactly one cycle. The counter wraps and continues, so pulses repeat exactly one period apart.
- R7: While low_power_i is 1, the prescaler and counter hold their values and no overflow occurs. Afterwards counting resumes from the held values.
- R8: While the enable bit is 0, counting stops and no overflow occurs.
- R9: If a key write and an overflow-causing counter step fall on the same edge, the clear wins and no overflow is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| low_power_i | input | 1 | High while the system is in a low-power mode |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 1 | 0 = control register, 1 = clear register |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | One-cycle watchdog interrupt pulse |
| rst_req_n_o | output | 1 | Active-low sticky reset request |

## Verification
A write is captured on the edge after it is driven. An overflow on edge E shows on irq_o or rst_req_n_o after E, so a result is due one edge after the counter step that causes it. A behavioural integer model in the bench advances on the same edges and is compared at every falling edge, where the outputs have settled. The timed checks count rising edges from the capturing edge of a write, or from reset release, up to the falling edge at which an output changes. They compare that count with the exact period, or with the window above three quarters and up to one full period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       en;
    logic [1:0] tsel;
    logic       rst_mode;
  } wdt_ctrl_t;

  localparam logic [7:0] WDT_KEY = 8'h4E;
  localparam wdt_ctrl_t  WDT_CTRL_RST = '{en: 1'b1, tsel: 2'b00, rst_mode: 1'b1};
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output wdt_ctrl_t  ctrl_o,
  output logic       clr_o
);
  wdt_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= WDT_CTRL_RST;
    else if (wr_en_i && !wr_sel_i) ctrl_q <= wdt_ctrl_t'(wr_data_i[3:0]);
  end

  // key check: only the exact key byte on the clear register clears
  assign clr_o  = wr_en_i && wr_sel_i && (wr_data_i == WDT_KEY);
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic [1:0] tsel_i,
  output logic       tick_o
);
  localparam int PW = BASE_LOG2 + 4;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask_a [4];
  logic [PW-1:0] sel_mask;

  // one tap mask per time code; code 3 is the shortest period
  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int TAP = BASE_LOG2 + 2 * (3 - g) - 2;
    localparam logic [PW:0] ONEHOT = (PW + 1)'(1) << TAP;
    localparam logic [PW:0] FULL = ONEHOT - (PW + 1)'(1);
    assign mask_a[g] = FULL[PW-1:0];
  end

  assign sel_mask = mask_a[tsel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (active_i) pre_q <= pre_q + 1'b1;
  end

  assign tick_o = active_i && ((pre_q & sel_mask) == sel_mask);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(pre_q));
endmodule

// File: rtl/wdt_overflow.sv
module wdt_overflow (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  input  logic rst_mode_i,
  output logic irq_o,
  output logic rst_req_n_o
);
  logic [1:0] cnt_q;
  logic       irq_q;
  logic       req_q;
  logic       ovf;

  assign ovf = tick_i && !clr_i && (cnt_q == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      irq_q <= ovf && !rst_mode_i;
      if (ovf && rst_mode_i) req_q <= 1'b1;
      if (clr_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq_o       = irq_q;
  assign rst_req_n_o = !req_q;

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_req_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n_o |=> !rst_req_n_o);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == 2'b00));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_power_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic       irq_o,
  output logic       rst_req_n_o
);
  wdt_ctrl_t ctrl;
  logic      clr;
  logic      tick;
  logic      active;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl), .clr_o(clr)
  );

  assign active = ctrl.en && !low_power_i;

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .active_i(active), .tsel_i(ctrl.tsel), .tick_o(tick)
  );

  wdt_overflow u_ovf (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(clr),
    .rst_mode_i(ctrl.rst_mode), .irq_o(irq_o), .rst_req_n_o(rst_req_n_o)
  );

  assert_no_tick_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tick);
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       low_power = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq;
  logic       rst_req_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  keyed_watchdog #(.BASE_LOG2(B)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .low_power_i(low_power), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_o(irq), .rst_req_n_o(rst_req_n)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_pre, m_cnt, m_en, m_tsel, m_mode;
  bit m_irq, m_req;

  function automatic int period_of(int code);
    return 1 << (B + 2 * (3 - code));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_en = 1; m_tsel = 0; m_mode = 1; m_irq = 0; m_req = 0;
    end else begin
      int step;
      bit act, tk, ov;
      step = period_of(m_tsel) / 4;
      act = (m_en != 0) && !low_power;
      tk = act && ((m_pre % step) == step - 1);
      ov = 0;
      if (wr_en && wr_sel && wr_data == 8'h4E) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == 3) begin ov = 1; m_cnt = 0; end
        else m_cnt++;
      end
      m_irq = ov && (m_mode == 0);
      if (ov && m_mode == 1) m_req = 1;
      if (act) m_pre++;
      if (wr_en && !wr_sel) begin
        m_en = wr_data[3]; m_tsel = wr_data[2:1]; m_mode = wr_data[0];
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(irq == m_irq, "R6 model irq", irq, m_irq);
      check(rst_req_n == !m_req, "R5 model rst_req_n", rst_req_n, !m_req);
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // edges until irq seen (called at a negedge)
  task automatic wait_irq(output int d);
    d = 0;
    while (d < 5000) begin
      @(posedge clk); d++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq == 1'b0 && rst_req_n == 1'b1, "R1 reset outputs", {irq, rst_req_n}, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    int d;
    int n;
    @(negedge clk);
    do_reset();
    // R1 R2: default period 2^(B+6), reset mode
    d = 0;
    while (rst_req_n && d < 3000) begin @(posedge clk); d++; @(negedge clk); end
    check(d == period_of(0), "R1 R2 default timeout", d, period_of(0));
    repeat (20) @(negedge clk);
    check(rst_req_n == 1'b0, "R5 request sticky", rst_req_n, 0);

    do_reset();
    // R2 R6: code 11, interrupt mode, periodic pulses
    wr(1'b0, 8'h0E);
    wr(1'b1, 8'h4E);
    wait_irq(d);
    for (int i = 0; i < 3; i++) begin
      wait_irq(d);
      check(d == period_of(3), "R6 irq spacing", d, period_of(3));
    end
    check(rst_req_n == 1'b1, "R6 no reset in irq mode", rst_req_n, 1);

    // R9: clear on the same edge as the overflow step
    repeat (15) @(negedge clk);
    wr(1'b1, 8'h4E);
    check(irq == 1'b0, "R9 clear beats overflow", irq, 0);
    wait_irq(d);
    check(d == period_of(3), "R9 next overflow", d, period_of(3));

    // R3: clears at random prescaler phase, code 10
    wr(1'b0, 8'h0C);
    for (int i = 0; i < 6; i++) begin
      repeat ($urandom_range(1, 40)) @(negedge clk);
      wr(1'b1, 8'h4E);
      wait_irq(d);
      check(d > period_of(2) * 3 / 4 && d <= period_of(2), "R3 window after clear", d, period_of(2));
    end

    // R4: wrong key bytes do not clear
    wr(1'b1, 8'h4E);
    wr(1'b1, 8'h4F);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hE4);
    wait_irq(d);
    check(d + 3 > period_of(2) * 3 / 4 && d + 3 <= period_of(2), "R4 bad keys ignored", d + 3, period_of(2));

    // R7: low-power freeze, code 11
    wr(1'b0, 8'h0E);
    low_power = 1'b1;
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (irq) n++; end
    check(n == 0, "R7 no irq while frozen", n, 0);
    low_power = 1'b0;
    wait_irq(d);
    check(d <= period_of(3) + 1, "R7 resumes", d, period_of(3));

    // R8: enable bit off
    wr(1'b0, 8'h06);
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (irq) n++; end
    check(n == 0, "R8 disabled no irq", n, 0);
    wr(1'b0, 8'h0E);
    wait_irq(d);
    check(irq == 1'b1, "R8 re-enabled irq", irq, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule